// File: doc/BRIEF.md
# LVDT Stimulus Amplitude Calculator

This block turns position commands into signed amplitude words for an electronic stand-in of linear or rotary differential transformers. It holds several channel pairs, each with an A and a B output. Each amplitude is the product of a measured excitation amplitude, a per-pair transformation ratio and a position-dependent factor. The words go on to a downstream sine or DAC stage that is outside this block.

Each pair runs in one of two modes. In paired (three/four-wire) mode the A position alone drives two complementary secondary amplitudes that sum to the full ratio-scaled excitation. In split (two-wire) mode the A and B positions drive two independent signed differential amplitudes. A simple write port loads the positions, ratios, mode bits and output enables. A strobe loads a new excitation word. A four-stage pipeline recomputes every output, and a valid pulse marks each refreshed result.

Top module: `lvdt_amp_calc`

## Requirements
- R1: Positions are 16-bit two's complement with 32768 meaning full scale. In paired mode, A = trunc(E·r·(32768+p)/65536000) and B = trunc(E·r·(32768−p)/65536000), where E is the latched excitation, r the pair's ratio word and p the A position.
- R2: In split mode each output is sign(p)·trunc(E·r·|2p|/65536000). A uses the A position and B uses the B position, independently.
- R3: The ratio word is the ratio times 1000. A write above 2000 stores 2000. The reset value is 1000, and one ratio word scales both outputs of a pair.
- R4: In paired mode neither output of the pair is ever negative.
- R5: In paired mode a write to that pair's B position is dropped. The B position keeps its old value, and that value shows up once the pair is switched to split mode.
- R6: Enable bit i gates both outputs of pair i. A disabled pair outputs zero. All pairs are disabled after reset.
- R7: Mode bit i set to 1 selects split mode for pair i, and 0 selects paired mode. All pairs are in paired mode after reset.
- R8: Results saturate to the signed 16-bit range: above 32767 gives 32767, and below −32768 gives −32768.
- R9: For each write or excitation strobe sampled at clock edge k, `amp_vld` is high for one cycle after edge k+4. The outputs show the new result from that same edge onward and do not change otherwise.
- R10: The address map with N pairs: A position of pair i at i, B position at N+i, ratio at 2N+i, mode bits at 3N, enable bits at 3N+1. Mode and enable use bits [N−1:0] of the write data.
- R11: The excitation word is taken only when `exc_vld` is high. Changes on `exc_in` without the strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW = clog2(3·NPAIR+2) | Register address |
| wr_data | input | 16 | Register write data |
| exc_vld | input | 1 | Excitation update strobe |
| exc_in | input | 16 | Measured excitation amplitude, unsigned |
| amp_vld | output | 1 | One-cycle pulse marking a refreshed result |
| amp_a | output | 16·NPAIR | A-channel amplitudes, pair i at bits [16i+15:16i], signed |
| amp_b | output | 16·NPAIR | B-channel amplitudes, pair i at bits [16i+15:16i], signed |

## Verification
The bench builds the block with its defaults: four pairs, a ratio ceiling of 2000 and a reset ratio of 1000. Four pairs let paired and split modes, enabled and disabled pairs, and clamped and zero ratios sit side by side in one result word. With the 2000 ceiling and an excitation near 60000, the calculation overflows in both directions, so both saturation limits are reached. A pseudo-random run of writes, including out-of-range ratio words, is compared against a scoreboard model after every write or excitation update.

// File: rtl/lvdt_amp_calc.sv
module lvdt_amp_calc #(
  parameter int NPAIR     = 4,
  parameter int RATIO_MAX = 2000,
  parameter int RATIO_RST = 1000,
  localparam int AW = $clog2(3*NPAIR+2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [15:0]         wr_data,
  input  logic                exc_vld,
  input  logic [15:0]         exc_in,
  output logic                amp_vld,
  output logic [NPAIR*16-1:0] amp_a,
  output logic [NPAIR*16-1:0] amp_b
);
  localparam int RW  = $clog2(RATIO_MAX+1);
  localparam int GW  = 16 + RW;
  localparam int PW  = GW + 17;
  localparam int YW  = PW - 16;
  localparam int SH  = 37;
  localparam int MW  = 28;
  localparam logic [MW-1:0] RECIP = MW'(((64'd1 << SH) + 64'd999) / 64'd1000);
  localparam int QW  = YW + MW - SH;
  localparam int A_MODE = 3*NPAIR;
  localparam int A_EN   = 3*NPAIR + 1;

  logic signed [15:0] pos_a [NPAIR];
  logic signed [15:0] pos_b [NPAIR];
  logic [RW-1:0]      ratio [NPAIR];
  logic [NPAIR-1:0]   mode, en;
  logic [15:0]        exc;
  logic [4:0]         vsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAIR; i++) begin
        pos_a[i] <= '0;
        pos_b[i] <= '0;
        ratio[i] <= RW'(RATIO_RST);
      end
      mode <= '0;
      en   <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NPAIR; i++) begin
        if (int'(wr_addr) == i) pos_a[i] <= wr_data;
        if (int'(wr_addr) == NPAIR + i && mode[i]) pos_b[i] <= wr_data;
        if (int'(wr_addr) == 2*NPAIR + i)
          ratio[i] <= (int'(wr_data) > RATIO_MAX) ? RW'(RATIO_MAX) : wr_data[RW-1:0];
      end
      if (int'(wr_addr) == A_MODE) mode <= wr_data[NPAIR-1:0];
      if (int'(wr_addr) == A_EN)   en   <= wr_data[NPAIR-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc <= '0;
      vsh <= '0;
    end else begin
      if (exc_vld) exc <= exc_in;
      vsh <= {vsh[3:0], wr_en | exc_vld};
    end
  end

  assign amp_vld = vsh[4];

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic signed [17:0] term [2];
    logic [GW-1:0]      gain;
    logic               en1, en2, en3;

    always_comb begin
      if (mode[p]) begin
        term[0] = {pos_a[p][15], pos_a[p], 1'b0};
        term[1] = {pos_b[p][15], pos_b[p], 1'b0};
      end else begin
        term[0] = 18'sd32768 + 18'(pos_a[p]);
        term[1] = 18'sd32768 - 18'(pos_a[p]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gain <= '0;
        {en1, en2, en3} <= '0;
      end else begin
        gain <= GW'(exc) * GW'(ratio[p]);
        en1  <= en[p];
        en2  <= en1;
        en3  <= en2;
      end
    end

    for (genvar s = 0; s < 2; s++) begin : g_side
      logic [17:0]      negt;
      logic [16:0]      mag1;
      logic             neg1, neg2, neg3;
      logic [PW-1:0]    prod;
      logic [YW-1:0]    y2;
      logic [YW+MW-1:0] prod3;
      logic [QW-1:0]    q3;
      logic [15:0]      amp;

      assign negt  = -term[s];
      assign prod  = PW'(gain) * PW'(mag1);
      assign prod3 = (YW+MW)'(y2) * (YW+MW)'(RECIP);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mag1 <= '0;
          y2   <= '0;
          q3   <= '0;
          amp  <= '0;
          {neg1, neg2, neg3} <= '0;
        end else begin
          mag1 <= term[s][17] ? 17'(negt) : 17'(term[s]);
          neg1 <= term[s][17];
          y2   <= YW'(prod >> 16);
          neg2 <= neg1;
          q3   <= QW'(prod3 >> SH);
          neg3 <= neg2;
          if (!en3)
            amp <= '0;
          else if (!neg3)
            amp <= (q3 > QW'(32767)) ? 16'h7fff : q3[15:0];
          else
            amp <= (q3 >= QW'(32768)) ? 16'h8000 : 16'(-q3[15:0]);
        end
      end

      if (s == 0) begin : g_a
        assign amp_a[p*16 +: 16] = amp;
      end else begin : g_b
        assign amp_b[p*16 +: 16] = amp;
      end
    end
  end
endmodule

module lvdt_amp_calc_chk #(
  parameter int NPAIR = 4,
  parameter int AW    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [AW-1:0]       wr_addr,
  input logic                exc_vld,
  input logic                amp_vld,
  input logic [NPAIR*16-1:0] amp_a,
  input logic [NPAIR*16-1:0] amp_b,
  input logic [NPAIR-1:0]    mode,
  input logic [NPAIR-1:0]    en,
  input logic signed [15:0]  pos_b [NPAIR]
);
  logic [2:0] warm;
  logic       ev;

  assign ev = wr_en | exc_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 3'd7) warm <= warm + 3'd1;
  end

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'd6) |-> (amp_vld == $past(ev, 5))); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'd6 && !$past(ev, 5)) |-> ($stable(amp_a) && $stable(amp_b))); // R9

  for (genvar p = 0; p < NPAIR; p++) begin : g_chk
    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 3'd6 && !$past(en[p], 4)) |->
        (amp_a[p*16 +: 16] == 16'd0 && amp_b[p*16 +: 16] == 16'd0)); // R6

    AST_PAIRED_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 3'd6 && !$past(mode[p], 4)) |->
        (!amp_a[p*16 + 15] && !amp_b[p*16 + 15])); // R4

    AST_B_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr) == NPAIR + p && !mode[p]) |=> $stable(pos_b[p])); // R5
  end
endmodule

bind lvdt_amp_calc lvdt_amp_calc_chk #(.NPAIR(NPAIR), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .exc_vld(exc_vld),
  .amp_vld(amp_vld), .amp_a(amp_a), .amp_b(amp_b), .mode(mode), .en(en), .pos_b(pos_b)
);

// File: tb/lvdt_amp_calc_tb.sv
`timescale 1ns/1ps
module lvdt_amp_calc_tb;
  localparam int NPAIR  = 4;
  localparam int AW     = $clog2(3*NPAIR+2);
  localparam int W      = NPAIR*16;
  localparam int A_POSA = 0;
  localparam int A_POSB = NPAIR;
  localparam int A_RAT  = 2*NPAIR;
  localparam int A_MODE = 3*NPAIR;
  localparam int A_EN   = 3*NPAIR + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, exc_vld, amp_vld;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data, exc_in;
  logic [W-1:0]  amp_a, amp_b;

  always #2.5 clk = ~clk;

  lvdt_amp_calc u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .exc_vld(exc_vld), .exc_in(exc_in), .amp_vld(amp_vld), .amp_a(amp_a), .amp_b(amp_b)
  );

  typedef struct {
    int           due;
    int           tag;
    logic [W-1:0] a;
    logic [W-1:0] b;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int   cyc = 0;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  int m_pa [NPAIR];
  int m_pb [NPAIR];
  int m_r  [NPAIR];
  bit m_mode [NPAIR];
  bit m_en   [NPAIR];
  int m_exc;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] amp_of(int e, int r, int t, bit on);
    longint mg, q;
    mg = (t < 0) ? -longint'(t) : longint'(t);
    q  = (longint'(e) * longint'(r) * mg) / 64'sd65536000;
    if (!on) return 16'h0;
    if (t < 0) q = -q;
    if (q > 32767) q = 32767;      // R8
    if (q < -32768) q = -32768;
    return 16'(q);
  endfunction

  task automatic push(int tag);
    exp_t it;
    int ta, tb;
    it.due = cyc + 5;
    it.tag = tag;
    for (int i = 0; i < NPAIR; i++) begin
      ta = m_mode[i] ? 2*m_pa[i] : 32768 + m_pa[i];
      tb = m_mode[i] ? 2*m_pb[i] : 32768 - m_pa[i];
      it.a[i*16 +: 16] = amp_of(m_exc, m_r[i], ta, m_en[i]);
      it.b[i*16 +: 16] = amp_of(m_exc, m_r[i], tb, m_en[i]);
    end
    sb.push_back(it);
  endtask

  task automatic wr(int addr, int data, int tag);
    int sd, ud;
    @(negedge clk);
    exc_vld = 1'b0;
    wr_en   = 1'b1;
    wr_addr = AW'(addr);
    wr_data = 16'(data);
    ud = data & 32'hffff;
    sd = (ud >= 32768) ? ud - 65536 : ud;
    if (addr < A_POSB) m_pa[addr] = sd;
    else if (addr < A_RAT) begin
      if (m_mode[addr-A_POSB]) m_pb[addr-A_POSB] = sd;   // R5
    end else if (addr < A_MODE) m_r[addr-A_RAT] = (ud > 2000) ? 2000 : ud;  // R3
    else if (addr == A_MODE) for (int i = 0; i < NPAIR; i++) m_mode[i] = ud[i];
    else if (addr == A_EN)   for (int i = 0; i < NPAIR; i++) m_en[i] = ud[i];
    push(tag);
  endtask

  task automatic exc(int v, int tag);
    @(negedge clk);
    wr_en   = 1'b0;
    exc_vld = 1'b1;
    exc_in  = 16'(v);
    m_exc   = v;
    push(tag);
  endtask

  task automatic exc_raw(int v);
    @(negedge clk);
    wr_en   = 1'b0;
    exc_vld = 1'b0;
    exc_in  = 16'(v);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    wr_en   = 1'b0;
    exc_vld = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (amp_vld) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R9", "valid pulse with nothing pending", 1, 0);
        end else begin
          cur = sb.pop_front();
          chk(cyc == cur.due, "R9", "valid pulse cycle", cyc, cur.due);
          for (int i = 0; i < NPAIR; i++) begin
            chk(amp_a[i*16 +: 16] == cur.a[i*16 +: 16], $sformatf("R%0d", cur.tag),
                $sformatf("pair %0d A", i), int'($signed(amp_a[i*16 +: 16])),
                int'($signed(cur.a[i*16 +: 16])));
            chk(amp_b[i*16 +: 16] == cur.b[i*16 +: 16], $sformatf("R%0d", cur.tag),
                $sformatf("pair %0d B", i), int'($signed(amp_b[i*16 +: 16])),
                int'($signed(cur.b[i*16 +: 16])));
          end
        end
      end else if (sb.size() > 0 && sb[0].due < cyc) begin
        cur = sb.pop_front();
        chk(1'b0, "R9", "missing valid pulse at cycle", cyc, cur.due);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog expired: actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    rst_n = 1'b0; wr_en = 1'b0; exc_vld = 1'b0; wr_addr = '0; wr_data = '0; exc_in = '0;
    for (int i = 0; i < NPAIR; i++) begin
      m_pa[i] = 0; m_pb[i] = 0; m_r[i] = 1000; m_mode[i] = 1'b0; m_en[i] = 1'b0;
    end
    m_exc = 0;
    repeat (3) @(negedge clk);
    // R6: reset state, outputs zero and no pulse
    chk(amp_a == '0, "R6", "reset amp_a", int'(amp_a[31:0]), 0);
    chk(amp_b == '0, "R6", "reset amp_b", int'(amp_b[31:0]), 0);
    chk(amp_vld == 1'b0, "R9", "reset amp_vld", int'(amp_vld), 0);
    rst_n = 1'b1;
    idle(2);

    wr(A_EN, 'hF, 6);                 // R6 enable all, R10 map
    exc(10000, 3);                    // R3 reset ratio 1000, R7 reset paired mode
    wr(A_POSA + 0, 16384, 1);         // R1
    wr(A_POSA + 1, -32768, 1);
    wr(A_POSA + 2, 32767, 4);         // R4 lower edge of paired output
    wr(A_POSA + 3, -1234, 1);
    wr(A_RAT + 1, 2500, 3);           // R3 clamp to 2000
    idle(3);
    wr(A_POSB + 0, 12345, 5);         // R5 dropped in paired mode
    wr(A_MODE, 'h1, 7);               // R7 pair 0 split, B shows retained 0
    wr(A_POSB + 0, -16384, 2);        // R2 independent B
    wr(A_POSA + 3, 20000, 9);         // R9 back-to-back writes
    wr(A_POSA + 3, -20000, 9);
    exc_raw(50000);                   // R11 no strobe
    wr(A_POSA + 2, 0, 11);
    idle(4);
    exc(60000, 8);
    wr(A_MODE, 'h3, 7);
    wr(A_POSA + 1, 32767, 8);         // R8 positive limit
    wr(A_POSB + 1, -32768, 8);        // R8 negative limit
    wr(A_RAT + 1, 0, 3);
    wr(A_EN, 'hB, 6);                 // R6 pair 2 off
    idle(8);

    seed = 32'h1234_5678;
    for (int k = 0; k < 80; k++) begin
      seed = seed * 1664525 + 1013904223;
      if (k % 9 == 0) exc(int'(seed >> 16), 11);
      else if (k % 5 == 0) wr(A_MODE + int'(seed[0]), int'(seed >> 16), 10);
      else wr(int'((seed >> 8) % (3*NPAIR)), int'(seed >> 16), (seed[3]) ? 1 : 2);
      if (k % 13 == 0) idle(3);
    end
    idle(12);
    chk(sb.size() == 0, "R9", "pending results after drain", sb.size(), 0);
    finish_run();
  end
endmodule